// File: doc/BRIEF.md
# Timebase Counter with Input Capture

This block produces a fixed-rate system tick and timestamps external events. A prescaler divides the core clock by 32. Each prescaled tick advances an 8-bit counter that runs from 00h to F9h and then returns to 00h, so one period is 250 ticks (8000 clocks). Each wrap raises a timebase flag. A control bit can make only every second wrap raise the flag, which doubles the flag period. Software cannot read or write the counter.

A capture input goes through a two-flop synchroniser and an edge detector. On the chosen edge, the current counter value is stored in a read-only capture register and a capture flag is raised. While that flag is set, later edges are ignored. Each flag has its own interrupt enable and its own registered interrupt output. A status read clears the timebase flag. A capture-register read clears the capture flag. If a flag-setting event and a clearing read land in the same cycle, the flag stays set.

Top module: `tbcap_timer`

## Requirements
- R1: After reset the counter starts at 0 and advances once every 32 clocks. The first advance happens at the 32nd rising edge after reset is released.
- R2: The counter passes from F9h to 00h on its 250th advance, which is the 8000th edge after reset release. With period doubling off, that wrap sets the timebase flag (status bit 0, address 0) and the flag then recurs every 8000 clocks.
- R3: With period doubling on (status bit 2), only every second wrap sets the timebase flag. The internal toggle is 0 while doubling is off, so the first wrap after doubling is enabled does not set the flag.
- R4: `tb_irq` is high exactly when the timebase flag is set and the timebase interrupt enable (status bit 1) is 1.
- R5: A read of address 0 returns the status as it was before the read, then clears the timebase flag.
- R6: If the timebase flag is being set in the same cycle as a read of address 0, the flag stays set.
- R7: A selected edge on `cap_pin` stores the counter value into the capture register (address 1) and sets the capture flag (status bit 5). The counter value stored is the one after the second edge that follows the pin change.
- R8: Status bit 4 chooses the capture edge: 0 for rising, 1 for falling. The opposite edge does not capture.
- R9: `cap_irq` is high exactly when the capture flag is set and the capture interrupt enable (status bit 3) is 1.
- R10: A read of address 1 clears the capture flag. While the flag is set, further edges neither change the capture register nor the flag. A read of address 0 leaves the capture flag unchanged.
- R11: Only status bits 1 to 4 are writable. Writes to addresses 1 to 3 and to bits 0, 5, 6 and 7 have no effect. Addresses 2 and 3 read as 0. After reset all readable values are 0.
- R12: Captured values follow the counter across its wrap. Two captures taken 100×32 clocks apart differ by 100 modulo 250.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register address for reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; also clears the flag that belongs to the addressed register |
| rd_data | output | 8 | Read data, registered, valid the cycle after the read strobe |
| cap_pin | input | 1 | Asynchronous capture input |
| tb_irq | output | 1 | Timebase interrupt request |
| cap_irq | output | 1 | Capture interrupt request |

## Verification
The counter is hidden, so a wrong prescaler, wrap value or doubling toggle shows up only as a timebase flag that arrives at the wrong edge. That fault is visible one period later, at the latest 16000 clocks after reset. A counter or capture path that is off by one tick shows in the captured value two edges after the pin change, and the captures taken after the wrap expose a wrong wrap point. A wrong flag priority or clear path changes the very next status or capture read.

// File: rtl/tbcap_pkg.sv
`timescale 1ns/1ps
package tbcap_pkg;
  localparam int unsigned REG_AW = 2;

  localparam logic [REG_AW-1:0] ADDR_STAT = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_CAPT = 2'd1;

  // status / control bit positions
  localparam int unsigned B_TBF   = 0;  // timebase flag (read-only)
  localparam int unsigned B_TBIE  = 1;  // timebase interrupt enable
  localparam int unsigned B_DBL   = 2;  // period doubling
  localparam int unsigned B_CIE   = 3;  // capture interrupt enable
  localparam int unsigned B_CFALL = 4;  // capture on falling edge
  localparam int unsigned B_CF    = 5;  // capture flag (read-only)
endpackage

// File: rtl/tbcap_prescaler.sv
`timescale 1ns/1ps
module tbcap_prescaler #(
  parameter int unsigned DIV = 32
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst)
      pre_q <= '0;
    else if (pre_q == LAST)
      pre_q <= '0;
    else
      pre_q <= pre_q + 1'b1;
  end

  assign tick = (pre_q == LAST);
endmodule

// File: rtl/tbcap_timebase.sv
`timescale 1ns/1ps
module tbcap_timebase #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned WRAP  = 249
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             dbl,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap_now,
  output logic             period_evt
);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(WRAP);

  logic [CNT_W-1:0] cnt_q;
  logic             half_q;

  assign wrap_now   = tick && (cnt_q == TOP);
  assign period_evt = wrap_now && (!dbl || half_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else begin
      if (tick)
        cnt_q <= wrap_now ? '0 : cnt_q + 1'b1;
      if (!dbl)
        half_q <= 1'b0;
      else if (wrap_now)
        half_q <= ~half_q;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/tbcap_capture.sv
`timescale 1ns/1ps
module tbcap_capture #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin,
  input  logic             fall_sel,
  input  logic             flag_busy,
  input  logic [CNT_W-1:0] cnt,
  output logic             cap_evt,
  output logic [CNT_W-1:0] cap_val
);
  logic [SYNC-1:0]  sync_q;
  logic             prev_q;
  logic             pin_s;
  logic             hit;
  logic [CNT_W-1:0] val_q;

  assign pin_s = sync_q[SYNC-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= SYNC'({sync_q, pin});
      prev_q <= pin_s;
    end
  end

  assign hit     = fall_sel ? (prev_q && !pin_s) : (!prev_q && pin_s);
  assign cap_evt = hit && !flag_busy;

  always_ff @(posedge clk) begin
    if (rst)
      val_q <= '0;
    else if (cap_evt)
      val_q <= cnt;
  end

  assign cap_val = val_q;
endmodule

// File: rtl/tbcap_regs.sv
`timescale 1ns/1ps
module tbcap_regs
  import tbcap_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] addr,
  input  logic              wr_en,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_en,
  input  logic              tb_evt,
  input  logic              cap_evt,
  input  logic [DW-1:0]     cap_val,
  output logic [DW-1:0]     ctrl,
  output logic              tb_flag,
  output logic              cap_flag,
  output logic [DW-1:0]     rd_data,
  output logic              tb_irq,
  output logic              cap_irq
);
  localparam logic [DW-1:0] WMASK = (DW'(1) << B_TBIE) | (DW'(1) << B_DBL) |
                                    (DW'(1) << B_CIE)  | (DW'(1) << B_CFALL);

  logic [DW-1:0] ctrl_q, ctrl_nx, stat_word, rd_nx;
  logic          tbf_q, tbf_nx, cf_q, cf_nx;
  logic          tb_clr, cap_clr;

  assign tb_clr  = rd_en && (addr == ADDR_STAT);
  assign cap_clr = rd_en && (addr == ADDR_CAPT);

  always_comb begin
    ctrl_nx = ctrl_q;
    if (wr_en && (addr == ADDR_STAT))
      ctrl_nx = wr_data & WMASK;
    // setting events win over clearing reads
    tbf_nx = tb_evt  ? 1'b1 : (tb_clr  ? 1'b0 : tbf_q);
    cf_nx  = cap_evt ? 1'b1 : (cap_clr ? 1'b0 : cf_q);

    stat_word        = ctrl_q;
    stat_word[B_TBF] = tbf_q;
    stat_word[B_CF]  = cf_q;

    rd_nx = '0;
    if (rd_en) begin
      case (addr)
        ADDR_STAT: rd_nx = stat_word;
        ADDR_CAPT: rd_nx = cap_val;
        default:   rd_nx = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      tbf_q   <= 1'b0;
      cf_q    <= 1'b0;
      rd_data <= '0;
      tb_irq  <= 1'b0;
      cap_irq <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_nx;
      tbf_q   <= tbf_nx;
      cf_q    <= cf_nx;
      rd_data <= rd_nx;
      tb_irq  <= tbf_nx && ctrl_nx[B_TBIE];
      cap_irq <= cf_nx  && ctrl_nx[B_CIE];
    end
  end

  assign ctrl     = ctrl_q;
  assign tb_flag  = tbf_q;
  assign cap_flag = cf_q;
endmodule

// File: rtl/tbcap_timer.sv
`timescale 1ns/1ps
module tbcap_timer
  import tbcap_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned PRESCALE = 32,
  parameter int unsigned WRAP_VAL = 249,
  parameter int unsigned SYNC     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] addr,
  input  logic              wr_en,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              rd_en,
  output logic [CNT_W-1:0]  rd_data,
  input  logic              cap_pin,
  output logic              tb_irq,
  output logic              cap_irq
);
  logic             tick;
  logic [CNT_W-1:0] cnt_w;
  logic             wrap_w;
  logic             period_evt;
  logic             cap_evt;
  logic [CNT_W-1:0] cap_val;
  logic [CNT_W-1:0] ctrl_q;
  logic             tb_flag;
  logic             cap_flag;

  tbcap_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  tbcap_timebase #(.CNT_W(CNT_W), .WRAP(WRAP_VAL)) u_tb (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .dbl        (ctrl_q[B_DBL]),
    .cnt        (cnt_w),
    .wrap_now   (wrap_w),
    .period_evt (period_evt)
  );

  tbcap_capture #(.CNT_W(CNT_W), .SYNC(SYNC)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .pin       (cap_pin),
    .fall_sel  (ctrl_q[B_CFALL]),
    .flag_busy (cap_flag),
    .cnt       (cnt_w),
    .cap_evt   (cap_evt),
    .cap_val   (cap_val)
  );

  tbcap_regs #(.DW(CNT_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .tb_evt   (period_evt),
    .cap_evt  (cap_evt),
    .cap_val  (cap_val),
    .ctrl     (ctrl_q),
    .tb_flag  (tb_flag),
    .cap_flag (cap_flag),
    .rd_data  (rd_data),
    .tb_irq   (tb_irq),
    .cap_irq  (cap_irq)
  );
endmodule

// File: rtl/tbcap_timer_chk.sv
`timescale 1ns/1ps
module tbcap_timer_chk
  import tbcap_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned WRAP  = 249
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic [CNT_W-1:0]  cnt,
  input logic              period_evt,
  input logic              tb_flag,
  input logic              tb_ie,
  input logic              tb_irq,
  input logic              cap_evt,
  input logic              cap_flag,
  input logic              cap_ie,
  input logic              cap_irq,
  input logic [CNT_W-1:0]  cap_val,
  input logic              rd_en,
  input logic [REG_AW-1:0] addr
);
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(WRAP));

  a_r1_step_on_tick: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));

  a_r2_flag_source: assert property (@(posedge clk) disable iff (rst)
    (!tb_flag && !period_evt) |=> !tb_flag);

  a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_STAT && !period_evt) |=> !tb_flag);

  a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
    period_evt |=> tb_flag);

  a_r4_tb_irq: assert property (@(posedge clk) disable iff (rst)
    tb_irq == (tb_flag && tb_ie));

  a_r9_cap_irq: assert property (@(posedge clk) disable iff (rst)
    cap_irq == (cap_flag && cap_ie));

  a_r7_capture: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> (cap_flag && cap_val == $past(cnt)));

  a_r10_blocked: assert property (@(posedge clk) disable iff (rst)
    cap_flag |-> !cap_evt);

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    cap_flag |=> $stable(cap_val));
endmodule

bind tbcap_timer tbcap_timer_chk #(.CNT_W(CNT_W), .WRAP(WRAP_VAL)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tick       (tick),
  .cnt        (cnt_w),
  .period_evt (period_evt),
  .tb_flag    (tb_flag),
  .tb_ie      (ctrl_q[tbcap_pkg::B_TBIE]),
  .tb_irq     (tb_irq),
  .cap_evt    (cap_evt),
  .cap_flag   (cap_flag),
  .cap_ie     (ctrl_q[tbcap_pkg::B_CIE]),
  .cap_irq    (cap_irq),
  .cap_val    (cap_val),
  .rd_en      (rd_en),
  .addr       (addr)
);

// File: tb/tbcap_timer_bench.sv
`timescale 1ns/1ps
module tbcap_timer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       cap_pin = 1'b0;
  logic       tb_irq;
  logic       cap_irq;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #2.5 clk = ~clk;

  tbcap_timer u_tbcap_timer (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .cap_pin (cap_pin),
    .tb_irq  (tb_irq),
    .cap_irq (cap_irq)
  );

  // edges since reset release: after the k-th edge cyc == k
  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; rd_en = 1'b0; wr_en = 1'b0; cap_pin = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    rd(2'd0, d); check("R11 reset status", d, 8'h00);
    rd(2'd1, d); check("R11 reset capture", d, 8'h00);
    check("R4 reset tb_irq", {7'd0, tb_irq}, 8'h00);
    check("R9 reset cap_irq", {7'd0, cap_irq}, 8'h00);
  endtask

  task automatic t_period();
    logic [7:0] d;
    do_reset();
    wr(2'd0, 8'h02);
    wait_to(7990);
    rd(2'd0, d); check("R1 no flag before period", d, 8'h02);
    check("R4 irq low before period", {7'd0, tb_irq}, 8'h00);
    wait_to(8005);
    check("R4 irq high with flag", {7'd0, tb_irq}, 8'h01);
    rd(2'd0, d); check("R2 flag after 8000 clocks", d, 8'h03);
    rd(2'd0, d); check("R5 read cleared flag", d, 8'h02);
    check("R5 irq dropped after read", {7'd0, tb_irq}, 8'h00);
    wait_to(15990);
    rd(2'd0, d); check("R2 no flag mid second period", d, 8'h02);
    wait_to(16005);
    rd(2'd0, d); check("R2 flag after second period", d, 8'h03);
  endtask

  task automatic t_prio();
    logic [7:0] d;
    do_reset();
    wait_to(7999);
    addr = 2'd0; rd_en = 1'b1;   // read sampled at the wrap edge
    @(negedge clk);
    rd_en = 1'b0;
    check("R6 coincident read sees old value", rd_data, 8'h00);
    rd(2'd0, d); check("R6 flag survives coincident read", d, 8'h01);
    rd(2'd0, d); check("R6 later read clears", d, 8'h00);
  endtask

  task automatic t_double();
    logic [7:0] d;
    do_reset();
    wr(2'd0, 8'h04);
    wait_to(8005);
    rd(2'd0, d); check("R3 first wrap skipped", d, 8'h04);
    wait_to(15990);
    rd(2'd0, d); check("R3 no flag before double period", d, 8'h04);
    wait_to(16005);
    check("R4 irq stays low when disabled", {7'd0, tb_irq}, 8'h00);
    rd(2'd0, d); check("R3 flag after double period", d, 8'h05);
  endtask

  task automatic t_capture();
    logic [7:0] d;
    do_reset();
    wr(2'd0, 8'h08);
    @(negedge clk); cap_pin = 1'b1;
    repeat (5) @(negedge clk);
    check("R9 cap_irq raised", {7'd0, cap_irq}, 8'h01);
    rd(2'd0, d); check("R7 capture flag set", d, 8'h28);
    rd(2'd0, d); check("R10 status read keeps capture flag", d, 8'h28);
    rd(2'd1, d); check("R7 captured early count", d, 8'h00);
    check("R9 cap_irq dropped", {7'd0, cap_irq}, 8'h00);
    rd(2'd0, d); check("R10 capture read cleared flag", d, 8'h08);
  endtask

  task automatic t_block();
    logic [7:0] d;
    do_reset();
    @(negedge clk); cap_pin = 1'b1;
    wait_to(100); cap_pin = 1'b0;
    wait_to(140); cap_pin = 1'b1;
    wait_to(200);
    rd(2'd1, d); check("R10 edge ignored while flag set", d, 8'h00);
    rd(2'd0, d); check("R10 flag cleared by capture read", d, 8'h00);
    wait_to(250); cap_pin = 1'b0;
    wait_to(300); cap_pin = 1'b1;
    wait_to(320);
    rd(2'd0, d); check("R10 capture re-armed", d, 8'h20);
    rd(2'd1, d); check("R7 capture value", d, 8'd9);
  endtask

  task automatic t_edge();
    logic [7:0] d;
    do_reset();
    wr(2'd0, 8'h10);
    @(negedge clk); cap_pin = 1'b1;
    repeat (6) @(negedge clk);
    rd(2'd0, d); check("R8 rising ignored in falling mode", d, 8'h10);
    wait_to(400); cap_pin = 1'b0;
    wait_to(410);
    rd(2'd0, d); check("R8 falling edge captured", d, 8'h30);
    rd(2'd1, d); check("R8 falling capture value", d, 8'((402) / 32));
  endtask

  task automatic t_wrapdiff();
    logic [7:0] d;
    do_reset();
    wait_to(6000); cap_pin = 1'b1;
    wait_to(6020);
    rd(2'd1, d); check("R12 first capture", d, 8'(((6002) / 32) % 250));
    wait_to(6050); cap_pin = 1'b0;
    wait_to(9200); cap_pin = 1'b1;
    wait_to(9220);
    rd(2'd1, d); check("R12 capture after wrap", d, 8'(((9202) / 32) % 250));
  endtask

  task automatic t_ro();
    logic [7:0] d;
    do_reset();
    wr(2'd1, 8'hFF);
    wr(2'd2, 8'hFF);
    wr(2'd0, 8'hFF);
    rd(2'd0, d); check("R11 only control bits writable", d, 8'h1E);
    rd(2'd1, d); check("R11 capture not writable", d, 8'h00);
    rd(2'd2, d); check("R11 unmapped reads zero", d, 8'h00);
    rd(2'd3, d); check("R11 unmapped reads zero", d, 8'h00);
    check("R11 no irq from writes", {6'd0, tb_irq, cap_irq}, 8'h00);
  endtask

  initial begin
    t_reset();
    t_ro();
    t_capture();
    t_block();
    t_edge();
    t_wrapdiff();
    t_period();
    t_prio();
    t_double();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule